// File: doc/BRIEF.md
# Error and Mode Flag Register with Set/Clear Commands

This block keeps eight sticky state bits for a serial controller: an operating-enable bit, a controller-select bit and six error flags (mode fault, transmit overrun, receive overrun, abort, transmit underrun and receive underrun). Software never edits these bits in place. Instead it writes a write-only command word in which every state bit owns a dedicated "set" bit and a dedicated "clear" bit. Any subset of the bits can therefore be changed in one write, with no read-modify-write, and bits whose command pair is left at zero stay as they are.

The shift engine and the FIFOs that detect error conditions lie outside this block. Each of them delivers a one-cycle event pulse. Four of those events pass through an enable register before they can latch their flag. The mode-fault and transmit-underrun events always latch. A level error interrupt is raised for as long as any of the six error flags is set. The enable bit and the controller-select bit do not drive the interrupt.

The register port is a plain single-cycle port. A write takes effect at the clock edge where `reg_wr` is high. A read is combinational from `reg_addr`. The port has no valid/ready handshake because it carries no data stream. The event inputs and the busy input are plain status pins.

Top module: `errstat_regs`

## Requirements
- R1: After reset, the status word reads 0 (busy excepted), the event-enable register reads 0 and `err_irq` is low.
- R2: A command write with a bit's set position at 1 and its clear position at 0 makes that bit read 1 from the next cycle on.
- R3: A command write with a bit's clear position at 1 and its set position at 0 makes that bit read 0 from the next cycle on, unless a hardware event for the same flag arrives in that cycle.
- R4: A command write that has both the set and the clear position of a bit at 1 leaves that bit unchanged.
- R5: The command word (address 2) uses these positions. Enable: clear 0, set 1. Controller-select: clear 2, set 3. Receive underrun: clear 4, set 5. Mode fault: clear 6, set 7. Clear 8/9/10/11 and set 12/13/14/15 act on transmit overrun, receive overrun, abort and transmit underrun, in that order.
- R6: The event-enable register (address 0) controls four events: bit 0 gates transmit overrun, bit 1 gates receive overrun, bit 2 gates abort and bit 3 gates receive underrun. An enabled event sets its flag on the next cycle. A disabled event leaves the flag unchanged.
- R7: The mode-fault and transmit-underrun events set their flags on the next cycle with no enable needed.
- R8: A hardware event and a command clear for the same flag in the same cycle leave the flag set.
- R9: `err_irq` is high exactly while at least one of status bits 7 to 12 is 1. Bits 0 and 1 have no influence on it.
- R10: The status word (address 1) shows enable at bit 0, controller-select at bit 1 and the errors at bits 7 to 12 (mode fault, transmit overrun, receive overrun, abort, transmit underrun, receive underrun). It shows `busy_in` at bit 13 in the same cycle. All other bits read 0, and the command address reads 0.
- R11: Writes to the status address change no state.
- R12: With no command write and no event, every flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Word address: 0 enable, 1 status, 2 command |
| reg_wr | input | 1 | Write strobe, one access per high cycle |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| busy_in | input | 1 | Engine busy level, reflected in status |
| evt_mode | input | 1 | Mode-fault event pulse |
| evt_tx_ovf | input | 1 | Transmit overrun event pulse |
| evt_rx_ovf | input | 1 | Receive overrun event pulse |
| evt_abort | input | 1 | Abort event pulse |
| evt_tx_unf | input | 1 | Transmit underrun event pulse |
| evt_rx_unf | input | 1 | Receive underrun event pulse |
| err_irq | output | 1 | Level error interrupt |

## Verification
A command write, an enable write or an event that is present at a clock edge is visible in the status word, the enable read-back and `err_irq` right after that edge, one register stage later. The busy bit and the read multiplexer have no delay. The bench drives every stimulus half a cycle before an edge and updates its model at that edge. It then sets the port to an idle read of the status address and compares 2 ns after the edge, so each check sees exactly one edge of effect. Random cycles mix commands, events and enable changes. Directed steps cover simultaneous set and clear, an event colliding with a clear, gated events and writes to the read-only address.

// File: rtl/errstat_pkg.sv
package errstat_pkg;
  localparam int NFLAG    = 8;
  localparam int BUSY_POS = 13;
  localparam int CMD_W    = 16;

  // flag index order: 0 enable, 1 select, 2 mode, 3 tx_ovf, 4 rx_ovf,
  // 5 abort, 6 tx_unf, 7 rx_unf
  function automatic int stat_pos(input int i);
    case (i)
      0: return 0;
      1: return 1;
      2: return 7;
      3: return 8;
      4: return 9;
      5: return 10;
      6: return 11;
      default: return 12;
    endcase
  endfunction

  function automatic int set_pos(input int i);
    case (i)
      0: return 1;
      1: return 3;
      2: return 7;
      3: return 12;
      4: return 13;
      5: return 14;
      6: return 15;
      default: return 5;
    endcase
  endfunction

  function automatic int clr_pos(input int i);
    case (i)
      0: return 0;
      1: return 2;
      2: return 6;
      3: return 8;
      4: return 9;
      5: return 10;
      6: return 11;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/errstat_cmd_decode.sv
module errstat_cmd_decode
  import errstat_pkg::*;
(
  input  logic             wr_hit,
  input  logic [CMD_W-1:0] cmd,
  output logic [NFLAG-1:0] set_v,
  output logic [NFLAG-1:0] clr_v
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_pair
    assign set_v[i] = wr_hit & cmd[set_pos(i)];
    assign clr_v[i] = wr_hit & cmd[clr_pos(i)];
  end
endmodule

// File: rtl/errstat_flag_cell.sv
module errstat_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic hw_i,
  output logic q_o
);
  logic q_nxt;

  always_comb begin
    q_nxt = q_o;
    if (hw_i)                q_nxt = 1'b1;
    else if (set_i && !clr_i) q_nxt = 1'b1;
    else if (clr_i && !set_i) q_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_nxt;
  end

  a_r2_set_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> q_o);
  a_r3_clr_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i && !hw_i) |=> !q_o);
  a_r4_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i && !hw_i) |=> $stable(q_o));
  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hw_i |=> q_o);
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i && !hw_i) |=> $stable(q_o));
endmodule

// File: rtl/errstat_readback.sv
module errstat_readback #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int ENA_W  = 4,
  parameter logic [ADDR_W-1:0] A_ENA  = 0,
  parameter logic [ADDR_W-1:0] A_STAT = 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] stat_word,
  input  logic [ENA_W-1:0]  ena,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (addr == A_STAT)     rdata = stat_word;
    else if (addr == A_ENA) rdata[ENA_W-1:0] = ena;
  end
endmodule

// File: rtl/errstat_regs.sv
module errstat_regs
  import errstat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              busy_in,
  input  logic              evt_mode,
  input  logic              evt_tx_ovf,
  input  logic              evt_rx_ovf,
  input  logic              evt_abort,
  input  logic              evt_tx_unf,
  input  logic              evt_rx_unf,
  output logic              err_irq
);
  localparam int ENA_W = 4;
  localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(2);

  logic [ENA_W-1:0] ena_q;
  logic [NFLAG-1:0] set_v, clr_v, hw_v, flag_q;
  logic [DATA_W-1:0] stat_word;
  logic cmd_hit, ena_hit;
  logic unused_hi;

  assign cmd_hit   = reg_wr && (reg_addr == A_CMD);
  assign ena_hit   = reg_wr && (reg_addr == A_ENA);
  assign unused_hi = ^reg_wdata[DATA_W-1:CMD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ena_q <= '0;
    else if (ena_hit) ena_q <= reg_wdata[ENA_W-1:0];
  end

  errstat_cmd_decode u_dec (
    .wr_hit(cmd_hit),
    .cmd   (reg_wdata[CMD_W-1:0]),
    .set_v (set_v),
    .clr_v (clr_v)
  );

  assign hw_v = {evt_rx_unf & ena_q[3], evt_tx_unf, evt_abort & ena_q[2],
                 evt_rx_ovf & ena_q[1], evt_tx_ovf & ena_q[0], evt_mode,
                 2'b00};

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    errstat_flag_cell u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(set_v[i]),
      .clr_i(clr_v[i]),
      .hw_i (hw_v[i]),
      .q_o  (flag_q[i])
    );
  end

  always_comb begin
    stat_word = '0;
    for (int i = 0; i < NFLAG; i++) stat_word[stat_pos(i)] = flag_q[i];
    stat_word[BUSY_POS] = busy_in;
  end

  errstat_readback #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ENA_W(ENA_W),
    .A_ENA(A_ENA), .A_STAT(A_STAT)
  ) u_rd (
    .addr     (reg_addr),
    .stat_word(stat_word),
    .ena      (ena_q),
    .rdata    (reg_rdata)
  );

  assign err_irq = |flag_q[NFLAG-1:2];

  a_r6_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ena_q[0] && !flag_q[3] && !cmd_hit) |=> !flag_q[3]);
  a_r6_gated_on: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_q[2] && evt_abort) |=> flag_q[5]);
  a_r7_mode_always: assert property (@(posedge clk) disable iff (!rst_n)
    evt_mode |=> err_irq);
  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_irq) |-> $past(cmd_hit || evt_mode || evt_tx_unf ||
                             evt_tx_ovf || evt_rx_ovf || evt_abort || evt_rx_unf));
  a_r11_stat_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STAT && hw_v == '0) |=> ($stable(flag_q) && $stable(ena_q)));
endmodule

// File: tb/tb_errstat_regs.sv
module tb_errstat_regs;
  logic clk = 0, rst_n = 0;
  logic [1:0]  reg_addr = 1;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic busy_in = 0, evt_mode = 0, evt_tx_ovf = 0, evt_rx_ovf = 0;
  logic evt_abort = 0, evt_tx_unf = 0, evt_rx_unf = 0, err_irq;

  int n_tests = 0, n_fail = 0;
  logic [15:0] exp_stat = 0;
  logic [3:0]  exp_en = 0;

  always #4 clk = ~clk;

  errstat_regs dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R5/R6/R7/R8 model, positions written from the requirements
  function automatic logic [15:0] next_stat(logic [15:0] s, logic [3:0] en,
      logic wr, logic [1:0] a, logic [15:0] w, logic [5:0] ev);
    int pos[8] = '{0, 1, 7, 8, 9, 10, 11, 12};
    int sp[8]  = '{1, 3, 7, 12, 13, 14, 15, 5};
    int cp[8]  = '{0, 2, 6, 8, 9, 10, 11, 4};
    logic [7:0] hw;
    logic [15:0] n = s;
    // ev: 0 mode,1 tx_ovf,2 rx_ovf,3 abort,4 tx_unf,5 rx_unf
    hw = {ev[5] & en[3], ev[4], ev[3] & en[2], ev[2] & en[1], ev[1] & en[0], ev[0], 2'b00};
    for (int i = 0; i < 8; i++) begin
      logic st, cl;
      st = wr && a == 2 && w[sp[i]];
      cl = wr && a == 2 && w[cp[i]];
      if (hw[i])          n[pos[i]] = 1'b1;
      else if (st && !cl) n[pos[i]] = 1'b1;
      else if (cl && !st) n[pos[i]] = 1'b0;
    end
    return n;
  endfunction

  task automatic cycle(string req, logic wr, logic [1:0] a, logic [15:0] w,
                       logic [5:0] ev, logic busy);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = {16'h0, w}; busy_in = busy;
    {evt_rx_unf, evt_tx_unf, evt_abort, evt_rx_ovf, evt_tx_ovf, evt_mode} = ev;
    @(posedge clk);
    exp_stat = next_stat(exp_stat, exp_en, wr, a, w, ev);
    if (wr && a == 0) exp_en = w[3:0];
    #1;
    reg_wr = 0; reg_addr = 1;
    {evt_rx_unf, evt_tx_unf, evt_abort, evt_rx_ovf, evt_tx_ovf, evt_mode} = 0;
    #1;
    check({req, " status"}, reg_rdata, {16'h0, exp_stat | (16'(busy) << 13)});
    check({req, " R9 irq"}, {31'h0, err_irq}, {31'h0, |exp_stat[12:7]});
  endtask

  initial begin
    #(200000 * 8);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    #10 rst_n = 1;
    @(negedge clk); #1;
    check("R1 reset status", reg_rdata, 0);
    check("R1 reset irq", {31'h0, err_irq}, 0);
    reg_addr = 0; #1;
    check("R1 reset enables", reg_rdata, 0);
    reg_addr = 2; #1;
    check("R10 cmd reads zero", reg_rdata, 0);

    cycle("R2 R5 set enable", 1, 2, 16'h0002, 0, 0);
    check("R2 enable bit0", {31'h0, reg_rdata[0]}, 1);
    cycle("R2 R5 set select", 1, 2, 16'h0008, 0, 0);
    check("R9 no irq from bits0-1", {31'h0, err_irq}, 0);
    cycle("R4 both enable", 1, 2, 16'h0003, 0, 0);
    check("R4 enable held", {31'h0, reg_rdata[0]}, 1);
    cycle("R3 clear enable", 1, 2, 16'h0001, 0, 0);
    check("R3 enable cleared", {31'h0, reg_rdata[0]}, 0);
    cycle("R10 busy", 0, 1, 0, 0, 1);
    check("R10 busy bit13", {31'h0, reg_rdata[13]}, 1);
    cycle("R5 set all errors", 1, 2, 16'hF0A0, 0, 0);
    check("R5 error bits", reg_rdata, 32'h1F82);
    cycle("R11 write status", 1, 1, 16'h0000, 0, 0);
    check("R11 unchanged", reg_rdata, 32'h1F82);
    cycle("R5 clear all errors", 1, 2, 16'h0F50, 0, 0);
    check("R9 irq low", {31'h0, err_irq}, 0);
    cycle("R6 disabled event", 0, 1, 0, 6'b101110, 0);
    check("R6 disabled no set", reg_rdata, 32'h0002);
    cycle("R12 idle", 0, 1, 0, 0, 0);
    cycle("R12 write enables", 1, 0, 16'h000F, 0, 0);
    reg_addr = 0; #1;
    check("R6 enable readback", reg_rdata, 32'hF);
    cycle("R6 enabled abort", 0, 1, 0, 6'b001000, 0);
    check("R6 abort set", {31'h0, reg_rdata[10]}, 1);
    cycle("R8 event vs clear", 1, 2, 16'h0400, 6'b001000, 0);
    check("R8 abort stays", {31'h0, reg_rdata[10]}, 1);
    cycle("R7 mode event", 1, 0, 16'h0000, 6'b010001, 0);
    check("R7 mode+txunf set", reg_rdata & 32'h0880, 32'h0880);

    for (int k = 0; k < 400; k++) begin
      logic [1:0] a;
      a = 2'($urandom_range(0, 2));
      cycle("R12 random", 1'($urandom), a, 16'($urandom), 6'($urandom & $urandom), 1'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule